// File: doc/BRIEF.md
# Single-Step Accumulator Processor

This block is an instruction-granular model of a small accumulator machine. Each clock on which `step_i` is high completes one whole architectural step. That step is either an interrupt entry or the execution of the instruction fetched at the program counter. The visible state is the program counter, the accumulator, a return-address register and an interrupt-acknowledge flag. A word memory inside the block has combinational reads and synchronous writes and takes the place of external storage. It can be loaded through a preload port and inspected through a peek port. The block is meant to serve as a golden model that a cycle-accurate microcoded machine can be compared against, one instruction at a time.

Words are 16 bits wide. The opcode sits in bits 15:13 and the address field in bits 12:0. The memory is indexed by the low bits of an address field, so a small default memory aliases the upper address bits. All arithmetic wraps modulo 2^16. The reset input is asynchronous and active low. Its release is synchronised inside the block, so state leaves reset two clock edges after `rst_ni` rises.

Top module: `acc_cpu_step`

## Requirements
- R1: While reset is active, the program counter, accumulator, return register and acknowledge flag all read zero. This holds even when they held other values before reset.
- R2: On a clock with `step_i` low, the program counter, accumulator, return register, acknowledge flag and the memory contents stay unchanged. The preload port is the only exception, and it still writes. This holds whatever `ireq_i` does.
- R3: On a step where `ireq_i` is high and the acknowledge flag is clear, the block enters an interrupt. The old program counter goes to the return register, the program counter becomes 0 and the flag is set. No instruction executes, the accumulator is unchanged, and a store instruction at the program counter writes nothing.
- R4: While the acknowledge flag is set, `ireq_i` is ignored and the step executes the fetched instruction as normal.
- R5: The instruction is the memory word indexed by the low index bits of the program counter's address field (bits 12:0). Its opcode is bits 15:13, and any operand is the word indexed by the low bits of the instruction's own address field.
- R6: Opcode 0 (jump if zero) loads the whole instruction word into the program counter when the accumulator is zero. Otherwise it increments the program counter. Opcode 1 (jump) always loads the whole instruction word, opcode bits included.
- R7: Opcode 2 adds the operand to the accumulator and opcode 3 subtracts the operand from it. Both wrap modulo 2^16 and increment the program counter.
- R8: Opcode 4 loads the operand into the accumulator and increments the program counter.
- R9: Opcode 5 writes the accumulator to the memory word at the instruction's address field and increments the program counter. The new value is visible on the peek port after that clock.
- R10: Opcode 6 copies the return register into the program counter and clears the acknowledge flag. Opcode 7 only increments the program counter.
- R11: A preload writes `load_data_i` at `load_idx_i` on the clock where `load_en_i` is high. When a store instruction targets the same word on that clock, the preloaded value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| step_i | input | 1 | Complete one architectural step on this clock |
| ireq_i | input | 1 | Interrupt request level |
| load_en_i | input | 1 | Preload write enable |
| load_idx_i | input | IDX_W (8) | Preload word index |
| load_data_i | input | WORD_W (16) | Preload data |
| peek_idx_i | input | IDX_W (8) | Memory inspection index |
| peek_data_o | output | WORD_W (16) | Memory word at `peek_idx_i`, combinational |
| pc_o | output | WORD_W (16) | Program counter |
| acc_o | output | WORD_W (16) | Accumulator |
| rtn_o | output | WORD_W (16) | Return-address register |
| iack_o | output | 1 | Interrupt-acknowledge flag |

## Verification
Two pairs of functions can fall on the same clock. The first pair is interrupt entry and a store instruction. The bench runs the program until the word at the program counter is a store, then raises `ireq_i` for that step. It expects the vector and the saved return address, and it expects the target memory word to keep its earlier preloaded value. The second pair is a preload and a store aimed at the same word. The bench times a preload to land on the exact step that executes a store and expects the preload data to survive. The behavioural reference model in the bench applies the store first and the preload second, and it compares the whole architectural state on every clock.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_JZR = 3'd0,
    OP_JMP = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_LDA = 3'd4,
    OP_STA = 3'd5,
    OP_RFI = 3'd6,
    OP_NOP = 3'd7
  } opcode_e;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned NRD    = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          ld_we_i,
  input  logic [IDX_W-1:0]              ld_idx_i,
  input  logic [WORD_W-1:0]             ld_data_i,
  input  logic                          st_we_i,
  input  logic [IDX_W-1:0]              st_idx_i,
  input  logic [WORD_W-1:0]             st_data_i,
  input  logic [NRD-1:0][IDX_W-1:0]     rd_idx_i,
  output logic [NRD-1:0][WORD_W-1:0]    rd_data_o
);

  logic [WORD_W-1:0] words_q [DEPTH];
  logic              st_shadowed;

  // A preload to the same word on the same clock overrides the store.
  assign st_shadowed = ld_we_i && (ld_idx_i == st_idx_i);

  always_ff @(posedge clk_i) begin
    if (ld_we_i) begin
      words_q[ld_idx_i] <= ld_data_i;
    end
    if (st_we_i && !st_shadowed) begin
      words_q[st_idx_i] <= st_data_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = words_q[rd_idx_i[r]];
  end

endmodule

// File: rtl/acc_cpu_exec.sv
module acc_cpu_exec
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] rtn_i,
  input  logic              iack_i,
  input  logic              ireq_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] operand_i,
  output logic [WORD_W-1:0] pc_nxt_o,
  output logic [WORD_W-1:0] acc_nxt_o,
  output logic [WORD_W-1:0] rtn_nxt_o,
  output logic              iack_nxt_o,
  output logic              st_req_o,
  output logic [WORD_W-1:0] st_data_o
);

  opcode_e           op;
  logic              take_irq;
  logic [WORD_W-1:0] pc_inc;

  assign op       = opcode_e'(instr_i[WORD_W-1 -: OPC_W]);
  assign take_irq = ireq_i && !iack_i;
  assign pc_inc   = pc_i + WORD_W'(1);

  always_comb begin
    pc_nxt_o   = pc_i;
    acc_nxt_o  = acc_i;
    rtn_nxt_o  = rtn_i;
    iack_nxt_o = iack_i;
    st_req_o   = 1'b0;
    st_data_o  = acc_i;
    if (take_irq) begin
      pc_nxt_o   = '0;
      rtn_nxt_o  = pc_i;
      iack_nxt_o = 1'b1;
    end else begin
      unique case (op)
        OP_JZR: pc_nxt_o = (acc_i == '0) ? instr_i : pc_inc;
        OP_JMP: pc_nxt_o = instr_i;
        OP_ADD: begin
          acc_nxt_o = acc_i + operand_i;
          pc_nxt_o  = pc_inc;
        end
        OP_SUB: begin
          acc_nxt_o = acc_i - operand_i;
          pc_nxt_o  = pc_inc;
        end
        OP_LDA: begin
          acc_nxt_o = operand_i;
          pc_nxt_o  = pc_inc;
        end
        OP_STA: begin
          st_req_o = 1'b1;
          pc_nxt_o = pc_inc;
        end
        OP_RFI: begin
          pc_nxt_o   = rtn_i;
          iack_nxt_o = 1'b0;
        end
        default: pc_nxt_o = pc_inc;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_step.sv
module acc_cpu_step #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MEM_DEPTH = 256,
  localparam int unsigned IDX_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ireq_i,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [WORD_W-1:0] peek_data_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] rtn_o,
  output logic              iack_o
);

  localparam int unsigned NRD      = 3;
  localparam int unsigned RD_FETCH = 0;
  localparam int unsigned RD_OPND  = 1;
  localparam int unsigned RD_PEEK  = 2;

  logic                       core_rst_n;
  logic [WORD_W-1:0]          pc_q, acc_q, rtn_q;
  logic                       iack_q;
  logic [WORD_W-1:0]          pc_d, acc_d, rtn_d;
  logic                       iack_d;
  logic                       st_req, st_we;
  logic [WORD_W-1:0]          st_data;
  logic [WORD_W-1:0]          fetch_word;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][WORD_W-1:0] rd_data;

  acc_cpu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(core_rst_n)
  );

  assign rd_idx[RD_FETCH] = pc_q[IDX_W-1:0];
  assign fetch_word       = rd_data[RD_FETCH];
  assign rd_idx[RD_OPND]  = fetch_word[IDX_W-1:0];
  assign rd_idx[RD_PEEK]  = peek_idx_i;
  assign peek_data_o      = rd_data[RD_PEEK];

  assign st_we = step_i && core_rst_n && st_req;

  acc_cpu_mem #(
    .WORD_W(WORD_W),
    .DEPTH (MEM_DEPTH),
    .NRD   (NRD)
  ) u_mem (
    .clk_i    (clk_i),
    .ld_we_i  (load_en_i),
    .ld_idx_i (load_idx_i),
    .ld_data_i(load_data_i),
    .st_we_i  (st_we),
    .st_idx_i (fetch_word[IDX_W-1:0]),
    .st_data_i(st_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  acc_cpu_exec #(.WORD_W(WORD_W)) u_exec (
    .pc_i      (pc_q),
    .acc_i     (acc_q),
    .rtn_i     (rtn_q),
    .iack_i    (iack_q),
    .ireq_i    (ireq_i),
    .instr_i   (fetch_word),
    .operand_i (rd_data[RD_OPND]),
    .pc_nxt_o  (pc_d),
    .acc_nxt_o (acc_d),
    .rtn_nxt_o (rtn_d),
    .iack_nxt_o(iack_d),
    .st_req_o  (st_req),
    .st_data_o (st_data)
  );

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q   <= '0;
      acc_q  <= '0;
      rtn_q  <= '0;
      iack_q <= 1'b0;
    end else if (step_i) begin
      pc_q   <= pc_d;
      acc_q  <= acc_d;
      rtn_q  <= rtn_d;
      iack_q <= iack_d;
    end
  end

  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign rtn_o  = rtn_q;
  assign iack_o = iack_q;

endmodule

// File: rtl/acc_cpu_step_chk.sv
module acc_cpu_step_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic              ireq_i,
  input logic [WORD_W-1:0] instr_i,
  input logic [WORD_W-1:0] pc_i,
  input logic [WORD_W-1:0] acc_i,
  input logic [WORD_W-1:0] rtn_i,
  input logic              iack_i
);

  logic irq_go;
  assign irq_go = step_i && ireq_i && !iack_i;

  assert_hold_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(pc_i) && $stable(acc_i) && $stable(rtn_i) && $stable(iack_i)));

  assert_irq_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_go |=> (pc_i == '0 && iack_i && rtn_i == $past(pc_i) && acc_i == $past(acc_i)));

  assert_ack_only_from_request_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iack_i) |-> $past(step_i && ireq_i));

  assert_return_clears_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !irq_go && instr_i[WORD_W-1 -: 3] == 3'd6)
      |=> (pc_i == $past(rtn_i) && !iack_i));

  assert_nop_advances_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !irq_go && instr_i[WORD_W-1 -: 3] == 3'd7)
      |=> (pc_i == $past(pc_i) + WORD_W'(1) && acc_i == $past(acc_i)));

endmodule

bind acc_cpu_step acc_cpu_step_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (core_rst_n),
  .step_i (step_i),
  .ireq_i (ireq_i),
  .instr_i(fetch_word),
  .pc_i   (pc_o),
  .acc_i  (acc_o),
  .rtn_i  (rtn_o),
  .iack_i (iack_o)
);

// File: tb/acc_cpu_step_test.sv
module acc_cpu_step_test;

  localparam int W = 16;
  localparam int D = 256;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n, step, ireq, ld_en;
  logic [IW-1:0] ld_idx, peek_idx;
  logic [W-1:0]  ld_data, peek_data, pc, acc, rtn;
  logic          iack;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [W-1:0] mm [D];
  logic [W-1:0] mpc, macc, mrtn;
  logic         miack;

  always #5 clk = ~clk;

  acc_cpu_step uut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .ireq_i(ireq),
    .load_en_i(ld_en), .load_idx_i(ld_idx), .load_data_i(ld_data),
    .peek_idx_i(peek_idx), .peek_data_o(peek_data),
    .pc_o(pc), .acc_o(acc), .rtn_o(rtn), .iack_o(iack)
  );

  function automatic logic [W-1:0] mk(input int op, input int a);
    return {op[2:0], a[12:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic st, input logic irq, input logic ld,
                            input int la, input logic [W-1:0] ldd, output string tag);
    logic [W-1:0] ins, opnd;
    logic         we = 1'b0;
    int           wa = 0;
    tag = "R2";
    if (!rst_n) begin
      tag = "R1";
      mpc = '0; macc = '0; mrtn = '0; miack = 1'b0;
    end else if (st) begin
      if (irq && !miack) begin
        tag = "R3"; mrtn = mpc; mpc = '0; miack = 1'b1;
      end else begin
        ins  = mm[mpc[IW-1:0]];
        opnd = mm[ins[IW-1:0]];
        tag  = irq ? "R4 R5" : "R5";
        case (ins[15:13])
          3'd0: begin tag = {tag, " R6 jzr"}; mpc = (macc == 0) ? ins : mpc + 1; end
          3'd1: begin tag = {tag, " R6 jmp"}; mpc = ins; end
          3'd2: begin tag = {tag, " R7 add"}; macc = macc + opnd; mpc = mpc + 1; end
          3'd3: begin tag = {tag, " R7 sub"}; macc = macc - opnd; mpc = mpc + 1; end
          3'd4: begin tag = {tag, " R8 lda"}; macc = opnd; mpc = mpc + 1; end
          3'd5: begin tag = {tag, " R9 sta"}; we = 1'b1; wa = int'(ins[IW-1:0]); mpc = mpc + 1; end
          3'd6: begin tag = {tag, " R10 rfi"}; mpc = mrtn; miack = 1'b0; end
          default: begin tag = {tag, " R10 nop"}; mpc = mpc + 1; end
        endcase
      end
    end
    if (we) mm[wa] = macc;
    if (ld) begin mm[la] = ldd; tag = {tag, " R11"}; end
  endtask

  task automatic do_cycle(input logic st, input logic irq, input logic ld,
                          input int la, input logic [W-1:0] ldd);
    string tag;
    step = st; ireq = irq; ld_en = ld; ld_idx = la[IW-1:0]; ld_data = ldd;
    model_step(st, irq, ld, la, ldd, tag);
    @(posedge clk);
    @(negedge clk);
    check(pc == mpc, tag, "pc", pc, mpc);
    check(acc == macc, tag, "acc", acc, macc);
    check(rtn == mrtn, tag, "rtn", rtn, mrtn);
    check(iack == miack, tag, "iack", {15'd0, iack}, {15'd0, miack});
  endtask

  task automatic check_mem(input int a, input string tag);
    peek_idx = a[IW-1:0];
    #1;
    check(peek_data == mm[a], tag, "mem", peek_data, mm[a]);
  endtask

  function automatic logic [2:0] cur_op();
    logic [W-1:0] w = mm[mpc[IW-1:0]];
    return w[15:13];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1..all run did not complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    int tgt;
    rst_n = 1'b0; step = 0; ireq = 0; ld_en = 0; ld_idx = 0; ld_data = 0; peek_idx = 0;
    mpc = 0; macc = 0; mrtn = 0; miack = 0;
    @(negedge clk);
    repeat (2) do_cycle(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) do_cycle(0, 0, 0, 0, 0);

    // Preload: program, data and NOP fill.
    for (int i = 0; i < D; i++) begin
      case (i)
        0:   w = mk(4, 100);
        1:   w = mk(2, 101);
        2:   w = mk(3, 102);
        3:   w = mk(0, 10);
        10:  w = mk(5, 103);
        11:  w = mk(4, 100);
        12:  w = mk(0, 20);
        13:  w = mk(7, 0);
        14:  w = mk(1, 30);
        30:  w = mk(7, 0);
        31:  w = mk(5, 104);
        32:  w = mk(6, 0);
        100: w = 16'h0005;
        101: w = 16'hFFFE;
        102: w = 16'h0003;
        103: w = 16'h7777;
        104: w = 16'h6666;
        default: w = mk(7, 0);
      endcase
      do_cycle(0, 0, 1, i, w);
    end
    check_mem(100, "R11 preload");
    check_mem(14, "R11 preload");

    // Straight-line run with no interrupt requests.
    for (int i = 0; i < 14; i++) begin
      do_cycle(1, 0, 0, 0, 0);
      if (i == 4) check_mem(103, "R9 store");
    end
    check_mem(104, "R9 store");

    // Step low with a request pending: nothing moves.
    repeat (3) do_cycle(0, 1, 0, 0, 0);
    check_mem(103, "R2 idle memory");

    // Interrupt entry, then requests held high while acknowledged.
    for (int i = 0; i < 20; i++) do_cycle(1, 1, 0, 0, 0);

    // Interrupt arriving on a store step: no write.
    do_cycle(0, 0, 1, 103, 16'h1234);
    do_cycle(0, 0, 1, 104, 16'h4321);
    for (int i = 0; i < 40 && !(cur_op() == 3'd5 && !miack); i++) do_cycle(1, 0, 0, 0, 0);
    w = mm[mpc[IW-1:0]];
    tgt = int'(w[IW-1:0]);
    do_cycle(1, 1, 0, 0, 0);
    check_mem(tgt, "R3 store suppressed");

    // Preload and store to the same word on one clock.
    for (int i = 0; i < 60 && cur_op() != 3'd5; i++) do_cycle(1, 0, 0, 0, 0);
    w = mm[mpc[IW-1:0]];
    tgt = int'(w[IW-1:0]);
    do_cycle(1, 0, 1, tgt, 16'hBEEF);
    check_mem(tgt, "R11 preload wins");

    // Reset in the middle of a run clears the registers.
    do_cycle(1, 1, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    mpc = 0; macc = 0; mrtn = 0; miack = 0;
    check(pc == 0 && acc == 0 && rtn == 0 && !iack, "R1", "mid-run reset",
          pc | acc | rtn, 16'h0000);
    do_cycle(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) do_cycle(0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) do_cycle(1, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule